// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block holds a small bank of independent countdown channels. Each channel is controlled through two 32-bit words. The first word, the setup word, carries three things: a run flag, a repeat flag and a 29-bit start value. When software writes the setup word, the channel loads that value at once and, while the run flag is set, counts down by one on every clock where the shared tick qualifier is high.

A channel expires on the tick that arrives while its count is already zero. A start value of N therefore expires after N+1 ticks. In repeat mode the channel reloads the start value on expiry and keeps running. In single mode it drops its run flag and stops.

Expiry sets a sticky pending flag, which drives a level, active-high interrupt line for that channel. The flag stays set until software writes a one to bit 30 of the channel's second word, the status word. Reading the status word returns the live count and the pending flag. Channel k sits at byte offset 8·k, with the setup word at +0 and the status word at +4.

Top module: `tick_down_timer`

## Requirements
- R1: Reset clears every channel: setup and status words read 0 and all interrupt lines are low.
- R2: A write to the setup word (address bit 2 = 0) stores the run flag from bit 31, the repeat flag from bit 30 and the start value from bits 28:0. A read of the setup word returns those fields in the same positions, with bit 29 reading 0 whatever was written to it.
- R3: With start value N and the qualifier high on every cycle, the interrupt stays low after N qualified ticks and rises after tick N+1.
- R4: The count changes only on cycles where the qualifier is high. Idle cycles leave it unchanged.
- R5: In single mode (bit 30 = 0), expiry clears the run flag. The count then stays at 0 and further ticks cause no new expiry.
- R6: In repeat mode (bit 30 = 1), expiry reloads the start value and keeps the run flag set, so the channel expires again every N+1 ticks.
- R7: A setup write with bit 31 = 0 stops the channel. The loaded count then holds under ticks and no interrupt is raised.
- R8: A status-word write (address bit 2 = 1) with bit 30 = 1 clears the pending flag. The same write with bit 30 = 0 has no effect.
- R9: If an expiry and a clear write fall in the same cycle, the expiry wins and the interrupt stays high.
- R10: A read of the status word returns the live count in bits 28:0 and the pending flag in bit 30. All other bits read 0.
- R11: Each channel decodes only its own 8-byte window and drives only its own interrupt line. Activity in one channel leaves the others unchanged.
- R12: A setup write in a cycle with the qualifier high loads the written value. That cycle's tick is discarded and causes no expiry.
- R13: The full 29-bit start value 0x1FFFFFFF is accepted and reads back unchanged in both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count qualifier shared by all channels |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address: bit 2 picks the word, bits above 2 pick the channel |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read of the addressed word |
| irq | output | NUM_CH | Per-channel level interrupt, active high |

## Verification
The hardest situation to reach is the same-cycle collision between an expiry and a clear write. It needs the count already at zero, the pending flag already cleared, and then a single cycle in which both the write strobe and the qualifier are high. The stimulus gets there by stepping the count down with an exact number of ticks, clearing the pending flag, and then driving the clear write and one tick together. A similar exact alignment sets up the collision between a setup write and a zero-count tick.

// File: rtl/tdt_pkg.sv
// Package: shared field positions and widths for the countdown timer bank.
// Assumes 32-bit register words; the count field sits in the low bits.
package tdt_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 29;
    localparam int RUN_BIT  = 31;
    localparam int REP_BIT  = 30;
    localparam int CLR_BIT  = 30;
    localparam int PEND_BIT = 30;
    localparam int STRIDE_LSB = 3;   // 8-byte window per channel
    localparam int WSEL_BIT   = 2;   // 0: setup word, 1: status word
endpackage

// File: rtl/tdt_wr_decode.sv
// Write decoder: turns the shared write strobe and byte address into
// per-channel setup/clear strobes. Assumes byte address bits 1:0 are don't-care.
module tdt_wr_decode
    import tdt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] setup_wr,
    output logic [NUM_CH-1:0] clear_wr
);
    logic [CH_W-1:0] ch_idx;
    assign ch_idx = addr[ADDR_W-1:STRIDE_LSB];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        // Strobe generation for channel c
        always_comb begin
            setup_wr[c] = wr_en && (ch_idx == CH_W'(c)) && !addr[WSEL_BIT];
            clear_wr[c] = wr_en && (ch_idx == CH_W'(c)) &&  addr[WSEL_BIT];
        end
    end
endmodule

// File: rtl/tdt_channel.sv
// One countdown channel: n+1 expiry, single or repeat mode, sticky pending
// flag. Assumes setup_wr and clear_wr are never high together.
module tdt_channel
    import tdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              setup_wr,
    input  logic              clear_wr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              irq,
    output logic [WORD_W-1:0] setup_word,
    output logic [WORD_W-1:0] status_word
);
    logic             run_q;
    logic             rep_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             expire;

    // Expiry: a qualified tick while running at zero, unless a setup write lands
    assign expire = run_q && tick_en && (cnt_q == '0) && !setup_wr;

    // Run/mode/start/count state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rep_q   <= 1'b0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (setup_wr) begin
            run_q   <= wr_data[RUN_BIT];
            rep_q   <= wr_data[REP_BIT];
            start_q <= wr_data[CNT_W-1:0];
            cnt_q   <= wr_data[CNT_W-1:0];
        end else if (expire) begin
            if (rep_q) cnt_q <= start_q;
            else       run_q <= 1'b0;
        end else if (run_q && tick_en) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky pending flag; expiry has priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                           pend_q <= 1'b0;
        else if (expire)                      pend_q <= 1'b1;
        else if (clear_wr && wr_data[CLR_BIT]) pend_q <= 1'b0;
    end

    assign irq = pend_q;

    // Readback word assembly
    always_comb begin
        setup_word               = '0;
        setup_word[RUN_BIT]      = run_q;
        setup_word[REP_BIT]      = rep_q;
        setup_word[CNT_W-1:0]    = start_q;
        status_word              = '0;
        status_word[PEND_BIT]    = pend_q;
        status_word[CNT_W-1:0]   = cnt_q;
    end
endmodule

// File: rtl/tdt_rd_mux.sv
// Read multiplexer: selects the addressed channel word; out-of-range
// channel indices read as zero.
module tdt_rd_mux
    import tdt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][WORD_W-1:0] setup_words,
    input  logic [NUM_CH-1:0][WORD_W-1:0] status_words,
    output logic [WORD_W-1:0]             rd_data
);
    logic [CH_W-1:0] ch_idx;
    assign ch_idx = addr[ADDR_W-1:STRIDE_LSB];

    // Word selection
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_W'(i))
                rd_data = addr[WSEL_BIT] ? status_words[i] : setup_words[i];
        end
    end
endmodule

// File: rtl/tick_down_timer.sv
// Top: bank of NUM_CH countdown channels sharing one tick qualifier and one
// register port. Assumes a single-cycle write strobe and a combinational read.
module tick_down_timer
    import tdt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int ADDR_W = CH_W + STRIDE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0]             setup_wr;
    logic [NUM_CH-1:0]             clear_wr;
    logic [NUM_CH-1:0][WORD_W-1:0] setup_words;
    logic [NUM_CH-1:0][WORD_W-1:0] status_words;

    tdt_wr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .setup_wr (setup_wr),
        .clear_wr (clear_wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tdt_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_en     (tick_en),
            .setup_wr    (setup_wr[c]),
            .clear_wr    (clear_wr[c]),
            .wr_data     (wr_data),
            .irq         (irq[c]),
            .setup_word  (setup_words[c]),
            .status_word (status_words[c])
        );
    end

    tdt_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_rd (
        .addr         (addr),
        .setup_words  (setup_words),
        .status_words (status_words),
        .rd_data      (rd_data)
    );
endmodule

// File: rtl/tdt_checker.sv
// Checker: port-level temporal properties of the timer bank.
module tdt_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [NUM_CH-1:0] irq
);
    // R1: interrupts are low in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R3: an interrupt can only rise after a qualified tick
        assert_rise_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(tick_en));
        // R8: an interrupt can only fall after a register write
        assert_fall_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[c]) |-> $past(wr_en));
        // R4: with no tick and no write, interrupt lines hold
        assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick_en && !wr_en) |=> $stable(irq[c]));
    end
endmodule

bind tick_down_timer tdt_checker #(.NUM_CH(NUM_CH)) u_tdt_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .irq     (irq)
);

// File: tb/tick_down_timer_test.sv
// Scoreboard bench: driver tasks queue expectations, a monitor compares.
module tick_down_timer_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [1:0]  irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Scoreboard queues: kind 0 = read word, kind 1 = irq vector
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    tick_down_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Monitor: pops each expectation and compares against the outputs
    initial begin
        forever begin
            logic [31:0] act;
            wait (exp_q.size() > 0);
            #1;
            act = (kind_q[0] == 0) ? rd_data : {30'd0, irq};
            n_run++;
            if (act !== exp_q[0]) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", tag_q[0], act, exp_q[0]);
            end
            void'(kind_q.pop_front());
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string t);
        addr = a;
        kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
        wait (exp_q.size() == 0);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string t);
        kind_q.push_back(1); exp_q.push_back({30'd0, e}); tag_q.push_back(t);
        wait (exp_q.size() == 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk_rd(4'h0, 32'h0, "R1 setup word");
        chk_rd(4'h4, 32'h0, "R1 status word");
        chk_irq(2'b00, "R1 irq");

        // R2 / R13: field storage, bit 29 dropped, full-width start value
        wr(4'h0, 32'hBFFF_FFFF);
        chk_rd(4'h0, 32'h9FFF_FFFF, "R2 R13 setup readback");
        chk_rd(4'h4, 32'h1FFF_FFFF, "R13 count readback");
        wr(4'h0, 32'h0);

        // R3 / R5 / R10: single mode, N=4
        wr(4'h0, 32'h8000_0004);
        ticks(4);
        chk_irq(2'b00, "R3 no irq after N ticks");
        chk_rd(4'h4, 32'h0, "R10 count at zero");
        ticks(1);
        chk_irq(2'b01, "R3 irq after N+1 ticks");
        chk_rd(4'h0, 32'h0000_0004, "R5 run flag cleared");
        chk_rd(4'h4, 32'h4000_0000, "R10 pending bit 30");
        ticks(10);
        chk_rd(4'h4, 32'h4000_0000, "R5 stopped at zero");

        // R8: clear with bit 30 low ignored, high clears
        wr(4'h4, 32'hBFFF_FFFF);
        chk_irq(2'b01, "R8 clear without bit 30 ignored");
        wr(4'h4, 32'h4000_0000);
        chk_irq(2'b00, "R8 clear");

        // R4: counting gated by qualifier
        wr(4'h0, 32'h8000_000A);
        idle(5);
        chk_rd(4'h4, 32'h0000_000A, "R4 idle holds count");
        ticks(3);
        chk_rd(4'h4, 32'h0000_0007, "R4 three ticks");

        // R7: run flag clear stops
        wr(4'h0, 32'h0000_0003);
        ticks(10);
        chk_rd(4'h4, 32'h0000_0003, "R7 stopped count holds");
        chk_irq(2'b00, "R7 no irq");

        // R6: repeat mode, N=2
        wr(4'h0, 32'hC000_0002);
        ticks(3);
        chk_irq(2'b01, "R6 first expiry");
        chk_rd(4'h4, 32'h4000_0002, "R6 reload");
        wr(4'h4, 32'h4000_0000);
        ticks(2);
        chk_irq(2'b00, "R6 between expiries");
        ticks(1);
        chk_irq(2'b01, "R6 second expiry");
        chk_rd(4'h0, 32'hC000_0002, "R6 run flag kept");

        // R9: expiry beats simultaneous clear
        wr(4'h4, 32'h4000_0000);
        ticks(2);
        chk_rd(4'h4, 32'h0, "R9 count at zero");
        wr_en = 1'b1; addr = 4'h4; wr_data = 32'h4000_0000; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        chk_irq(2'b01, "R9 expiry wins");
        wr(4'h4, 32'h4000_0000);
        chk_irq(2'b00, "R9 later clear");

        // R12: setup write with tick at zero count
        wr(4'h0, 32'h8000_0001);
        ticks(1);
        chk_rd(4'h4, 32'h0, "R12 count at zero");
        wr_en = 1'b1; addr = 4'h0; wr_data = 32'h8000_0003; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        chk_irq(2'b00, "R12 tick discarded");
        chk_rd(4'h4, 32'h0000_0003, "R12 value loaded");

        // R11: second channel at offset 8, own irq line
        wr(4'h8, 32'h8000_0000);
        ticks(1);
        chk_irq(2'b10, "R11 only channel 1 irq");
        chk_rd(4'h4, 32'h0000_0002, "R11 channel 0 counted independently");
        chk_rd(4'h8, 32'h0, "R11 channel 1 stopped");
        chk_rd(4'hC, 32'h4000_0000, "R11 channel 1 pending");
        wr(4'hC, 32'h4000_0000);
        chk_irq(2'b00, "R11 channel 1 cleared");
        chk_rd(4'h0, 32'h8000_0003, "R11 channel 0 setup unchanged");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule